// File: doc/BRIEF.md
# Three-Level Bridge-Leg Gate Command Conditioner

This block sits between a pulse-width modulator and the carrier encoders of a three-level T-type bridge-leg. It takes four raw gate commands and returns four conditioned gate outputs. One bit stands for each power device. The devices at the rails are called outer devices (1 and 4). The devices that clamp to the midpoint are called inner devices (2 and 3). Each outer device is paired with one inner device: 1 with 2, and 4 with 3.

The block does two things. First, it gives each outer device turn-on priority over its inner partner. An inner device can therefore be commanded on all the time and is still held off whenever its outer partner is commanded on. Second, it delays every turn-on by a programmable underlap interval, counted in clock cycles, while every turn-off passes straight through. It also keeps the two complementary pairs (1 with 3, and 2 with 4) from ever being on together, whatever the commands are.

Inputs and outputs are synchronous to one fast clock. The outputs are registered.

Top module: `ul_leg_drive`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all four outputs go low at the next edge and every underlap count is cleared. Bit k of `cmd_i` and `gate_o` (k = 0..3) belongs to device k+1.
- R2: Inner output 2 (bit 1) is low after any edge at which command 1 (bit 0) was high. Inner output 3 (bit 2) is low after any edge at which command 4 (bit 3) was high. Output 1 and output 4 are not affected by the inner commands.
- R3: A channel's request is its command after the R2 priority is applied. A channel counts an edge as qualifying when its request is high and its opposite output was low before that edge. Outputs 1 and 3 are opposites, and so are outputs 2 and 4. The output asserts at the DEAD_CYC-th consecutive qualifying edge.
- R4: An asserted output drops at the first edge at which its request is sampled low.
- R5: Outputs 1 and 3 are never high together, and outputs 2 and 4 are never high together. If two opposites would assert at the same edge, the lower-numbered device wins: 1 over 3, and 2 over 4.
- R6: While an opposite output is high, a channel's count restarts. After the opposite output drops, the channel waits a full DEAD_CYC qualifying edges before it asserts.
- R7: When command 1 drops while command 2 stays high, output 2 waits the full DEAD_CYC qualifying edges before it asserts. Command 4 and output 3 behave the same way.
- R8: With command 2 held high and command 1 toggling slower than the underlap, output 2 follows the inverse of output 1, with the underlap inserted after each fall of output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 4 | Raw gate commands; bit k is device k+1 |
| gate_o | output | 4 | Conditioned gate outputs; bit k is device k+1 |

## Verification
The bench goes after three corner cases.

The first is an inner command held high while its outer partner toggles. A design without the priority term would drive output 1 and output 2 together. A design that drops the delay on release would bring output 2 up the cycle after output 1 falls.

The second is opposite channels raised on the same edge from idle. A design without the tie rule would assert outputs 1 and 3 together.

The third is an opposite that is released late. A design that lets its count run during the opposite's on-time would turn on with no underlap at all.

A long pseudo-random command sweep, checked against an edge-counting model, also catches off-by-one errors in the count: the output would rise one cycle early or one cycle late.

// File: rtl/ul_pkg.sv
package ul_pkg;
  typedef logic [3:0] leg_t;

  localparam int unsigned DEV1 = 0;
  localparam int unsigned DEV2 = 1;
  localparam int unsigned DEV3 = 2;
  localparam int unsigned DEV4 = 3;

  // Outer device beats inner partner: 1 over 2, 4 over 3.
  function automatic leg_t apply_priority(leg_t c);
    leg_t r;
    r       = c;
    r[DEV2] = c[DEV2] & ~c[DEV1];
    r[DEV3] = c[DEV3] & ~c[DEV4];
    return r;
  endfunction

  // Index of the complementary (never-together) output.
  function automatic int unsigned opposite(int unsigned k);
    return (k + 2) % 4;
  endfunction
endpackage

// File: rtl/ul_prio.sv
module ul_prio
  import ul_pkg::*;
(
  input  logic [3:0] cmd_i,
  output logic [3:0] req_o
);
  always_comb req_o = apply_priority(cmd_i);
endmodule

// File: rtl/ul_chan.sv
module ul_chan #(
  parameter int unsigned DEAD_CYC = 8,
  localparam int unsigned CW = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic opp_on_i,
  input  logic tie_i,
  output logic on_o,
  output logic go_o
);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          on_q;
  logic          at_lim;

  assign at_lim = (cnt_q == LAST);
  // Rise is granted on the DEAD_CYC-th qualifying edge, unless the opposite wins.
  assign go_o   = req_i & ~on_q & at_lim & ~opp_on_i & ~tie_i;
  assign on_o   = on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      on_q <= req_i & (on_q | go_o);
      if (!req_i || opp_on_i) cnt_q <= '0;
      else if (!at_lim)       cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_drop_now: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !on_q);
  a_r3_rise_after_count: assert property (@(posedge clk) disable iff (rst)
    (!on_q && req_i && !go_o) |=> !on_q);
  a_r6_blocked_by_opp: assert property (@(posedge clk) disable iff (rst)
    (opp_on_i && !on_q) |=> !on_q);
endmodule

// File: rtl/ul_leg_drive.sv
module ul_leg_drive #(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cmd_i,
  output logic [3:0] gate_o
);
  import ul_pkg::*;

  logic [3:0] req_w;
  logic [1:0] go_lo;
  logic [1:0] go_hi;

  ul_prio u_prio (.cmd_i(cmd_i), .req_o(req_w));

  for (genvar i = 0; i < 4; i++) begin : g_ch
    localparam int unsigned OPP = opposite(i);
    if (i < 2) begin : g_lo
      ul_chan #(.DEAD_CYC(DEAD_CYC)) u_ch (
        .clk(clk), .rst(rst), .req_i(req_w[i]), .opp_on_i(gate_o[OPP]),
        .tie_i(1'b0), .on_o(gate_o[i]), .go_o(go_lo[i]));
    end else begin : g_hi
      ul_chan #(.DEAD_CYC(DEAD_CYC)) u_ch (
        .clk(clk), .rst(rst), .req_i(req_w[i]), .opp_on_i(gate_o[OPP]),
        .tie_i(go_lo[i-2]), .on_o(gate_o[i]), .go_o(go_hi[i-2]));
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> gate_o == 4'b0000);
  a_r5_excl13: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[0] && gate_o[2]));
  a_r5_excl24: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[1] && gate_o[3]));
  a_r2_pri12: assert property (@(posedge clk) disable iff (rst)
    cmd_i[0] |=> !gate_o[1]);
  a_r2_pri43: assert property (@(posedge clk) disable iff (rst)
    cmd_i[3] |=> !gate_o[2]);
  a_r5_hi_grant3: assert property (@(posedge clk) disable iff (rst)
    go_hi[0] |=> gate_o[2]);
  a_r5_hi_grant4: assert property (@(posedge clk) disable iff (rst)
    go_hi[1] |=> gate_o[3]);
endmodule

// File: tb/tb_ul_leg_drive.sv
module tb_ul_leg_drive;
  localparam int DEAD = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmd = 4'b0000;
  logic [3:0] gate;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_out = 4'b0000;
  int m_run [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  ul_leg_drive #(.DEAD_CYC(DEAD)) dut (.clk(clk), .rst(rst), .cmd_i(cmd), .gate_o(gate));

  task automatic check(input string tag, input logic [3:0] exp);
    n_chk++;
    if (gate !== exp) begin
      n_bad++;
      $display("FAIL %s: gate=%b expected=%b at %0t", tag, gate, exp, $time);
    end
  endtask

  // Reference: run[k] = qualifying edges seen so far, capped at DEAD-1.
  task automatic model_edge(input logic [3:0] c);
    logic [3:0] rq, nxt;
    rq    = c;
    rq[1] = c[1] & ~c[0];
    rq[2] = c[2] & ~c[3];
    for (int k = 0; k < 4; k++) begin
      int o;
      bit tie;
      o      = (k + 2) % 4;
      tie    = (k >= 2) && nxt[k-2] && !m_out[k-2];
      nxt[k] = rq[k] && (m_out[k] || (m_run[k] == DEAD-1 && !m_out[o] && !tie));
    end
    for (int k = 0; k < 4; k++) begin
      int o;
      o = (k + 2) % 4;
      if (!rq[k] || m_out[o]) m_run[k] = 0;
      else if (m_run[k] < DEAD-1) m_run[k]++;
    end
    m_out = nxt;
  endtask

  task automatic step(input logic [3:0] c);
    cmd = c;
    @(posedge clk);
    if (rst) begin
      m_out = 4'b0000;
      m_run = '{0, 0, 0, 0};
    end else model_edge(c);
    @(negedge clk);
  endtask

  task automatic steps(input logic [3:0] c, input int n);
    for (int i = 0; i < n; i++) step(c);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: gate=%b expected=finish", gate);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    // R1: reset holds outputs low even with all commands high
    steps(4'b1111, 3);
    check("R1 reset with commands high", 4'b0000);
    rst = 1'b0;
    steps(4'b0000, 2);
    check("R1 idle after reset", 4'b0000);

    // R3 + R2: commands 1 and 2 together
    steps(4'b0011, DEAD-1);
    check("R3 not before DEAD edges", 4'b0000);
    step(4'b0011);
    check("R3/R2 out1 on, out2 held off", 4'b0001);
    steps(4'b0011, 3);
    check("R2 inner stays suppressed", 4'b0001);

    // R4 then R7: release outer, inner waits full underlap
    step(4'b0010);
    check("R4 out1 falls at once", 4'b0000);
    steps(4'b0010, DEAD-2);
    check("R7 inner waits underlap", 4'b0000);
    step(4'b0010);
    check("R7 inner asserts after DEAD edges", 4'b0010);

    // R8: cmd2 held, cmd1 toggles
    step(4'b0011);
    check("R8 out2 drops when cmd1 rises", 4'b0000);
    steps(4'b0011, DEAD-1);
    check("R8 out1 on, inverse of out2", 4'b0001);
    step(4'b0010);
    check("R8 out1 off", 4'b0000);
    steps(4'b0010, DEAD-1);
    check("R8 out2 back after underlap", 4'b0010);

    // R5: tie between 1 and 3 from idle
    steps(4'b0000, DEAD+1);
    check("R4 all low", 4'b0000);
    steps(4'b0101, DEAD);
    check("R5 tie goes to device 1", 4'b0001);
    steps(4'b0101, 6);
    check("R5 device 3 kept off", 4'b0001);

    // R6: opposite released, count restarts
    step(4'b0100);
    check("R6 out1 off", 4'b0000);
    steps(4'b0100, DEAD-1);
    check("R6 out3 still waiting", 4'b0000);
    step(4'b0100);
    check("R6 out3 after full underlap", 4'b0100);

    // R2 mirror: command 4 beats command 3
    steps(4'b0000, 2);
    steps(4'b1100, DEAD+2);
    check("R2 cmd4 overrides cmd3", 4'b1000);

    // Pseudo-random sweep against edge-counting model (R3 R4 R5 R6)
    lfsr = 16'hACE1;
    for (int t = 0; t < 4000; t++) begin
      logic [3:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[1:0] == 2'b00) c = lfsr[7:4]; else c = cmd;
      step(c);
      check("R3/R4/R5/R6 sweep model", m_out);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule